// File: doc/BRIEF.md
# Compact Serial Port with Byte Queues

This block is a small asynchronous serial port for a system-on-chip peripheral bus. Software reaches it through a word-addressed register window whose first eight slots follow the classic 16550 arrangement, followed by slots for separate enables, a short status word and a 16-bit rate divisor. Bytes written to the data slot enter an eight-entry transmit queue and are shifted out on `txd`. Bytes arriving on `rxd` are collected into an eight-entry receive queue and read back from the same data slot.

A frame is one low start bit, then 7 or 8 data bits sent least significant first, then one high stop bit. There is no parity. One bit lasts eight ticks of a divider fed from the system clock, so the bit time is 8 × divisor clocks. A single level interrupt reports receive data or transmit space, and is gated by a two-bit master enable. The request-to-send output is a plain software bit, and the clear-to-send input can be read back. Register bits that are not built accept writes and read as zero.

Bus reads return data in the same cycle. A read of the data slot removes the head of the receive queue, and a read of the line status slot clears the overrun flag. Both take effect at the clock edge that ends the access.

Top module: `lite_uart`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0, line status (offset 5) reads 0x0060 and interrupt identify (offset 2) reads 0x0001.
- R2: Line control (offset 3) bit 0 selects the frame length: 1 gives 8 data bits (value 3) and 0 gives 7 (value 0). A received 7-bit frame reads back with bit 7 at 0. The frame on `txd` is one start bit at 0, the data bits LSB first and one stop bit at 1, each lasting 8 × divisor clocks, where the divisor is offset 10 (a value of 0 acts as 1).
- R3: The receive queue holds 8 bytes in arrival order. A byte that completes while the queue is full and is not being read in that cycle is dropped and sets line status bit 1. A read of line status returns the flag and then clears it.
- R4: The transmit queue holds 8 bytes. Line status bit 5 is 1 exactly when it can take another byte. A data write made while it is full is discarded.
- R5: Line status bit 0 is 1 while the receive queue holds data. Bit 6 is 1 only when the transmit queue is empty and no frame is being sent.
- R6: Interrupt enable (offset 1) bit 0 arms the receive source (queue not empty) and bit 1 arms the transmit source (queue not full). `irq` is 1 only when bits 2 and 3 are both 1 and an armed source is active. Interrupt identify reads 0x0004 for receive, 0x0002 for transmit and 0x0001 for none, and receive wins when both are active.
- R7: Writing interrupt identify with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue.
- R8: Extra control (offset 8) bit 0 enables the receiver and bit 1 the transmitter, and both are 1 after reset. With the transmitter off, queued bytes wait and `txd` stays 1. With the receiver off, frames on the line are not collected.
- R9: Modem control (offset 4) bit 1 drives `rts`. Modem status (offset 6) bit 5 shows `cts` after a two-flop synchronizer.
- R10: Unbuilt bits read 0. Scratch (offset 7) keeps 8 bits, interrupt enable keeps 4, line control keeps 2.
- R11: The receiver samples `rxd` on the fourth of the eight ticks of each bit. It abandons a start bit whose line is already back at 1 at that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word offset of the register slot |
| bus_wdata | input | BUS_W (16) | Write data |
| bus_rdata | output | BUS_W (16) | Read data, valid in the access cycle |
| txd | output | 1 | Serial transmit line |
| rts | output | 1 | Request-to-send, set by software |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear-to-send, read by software |
| irq | output | 1 | Level interrupt request |

## Verification
The transmit queue can take a write from the bus in the same cycle that the transmitter removes its head. This is provoked by ten back-to-back data writes into an empty, running transmitter, with the serial line looped back to the receiver. The first byte leaves while the second arrives, so after nine writes the queue must report full, the tenth write must be dropped, and the receiver must collect the first eight bytes in order and flag the ninth as an overrun. The overrun flag and its clear-on-read are also checked across two successive status reads.

// File: rtl/lu_pkg.sv
`timescale 1ns/1ps
package lu_pkg;
    localparam logic [3:0] A_DATA  = 4'd0;
    localparam logic [3:0] A_IEN   = 4'd1;
    localparam logic [3:0] A_IID   = 4'd2;
    localparam logic [3:0] A_LINE  = 4'd3;
    localparam logic [3:0] A_MODEM = 4'd4;
    localparam logic [3:0] A_LSTAT = 4'd5;
    localparam logic [3:0] A_MSTAT = 4'd6;
    localparam logic [3:0] A_SCR   = 4'd7;
    localparam logic [3:0] A_XCTL  = 4'd8;
    localparam logic [3:0] A_XSTAT = 4'd9;
    localparam logic [3:0] A_DIV   = 4'd10;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } shift_st_e;
endpackage

// File: rtl/lu_fifo.sv
`timescale 1ns/1ps
module lu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign rdata = mem_q[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (clr) begin
            s_d     = '0;
            do_push = 1'b0;
        end else begin
            if (do_push) s_d.wp = bump(s_q.wp);
            if (do_pop)  s_d.rp = bump(s_q.rp);
            if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
            else if (!do_push && do_pop) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= wdata;
    end
endmodule

// File: rtl/lu_baud.sv
`timescale 1ns/1ps
module lu_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - 1'b1;
        tick  = (cnt_q >= limit);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lu_tx.sv
`timescale 1ns/1ps
module lu_tx import lu_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       len8,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    typedef struct packed {
        shift_st_e  st;
        logic [7:0] sh;
        logic [2:0] bitn;
        logic [2:0] tcnt;
    } tx_t;

    tx_t s_d, s_q;
    logic [2:0] last_bit;

    assign last_bit = len8 ? 3'd7 : 3'd6;
    assign busy     = (s_q.st != SH_IDLE);

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        unique case (s_q.st)
            SH_IDLE: begin
                if (en && !q_empty) begin
                    pop      = 1'b1;
                    s_d.st   = SH_START;
                    s_d.sh   = q_data;
                    s_d.tcnt = '0;
                    s_d.bitn = '0;
                end
            end
            SH_START: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == 3'd7) s_d.st = SH_DATA;
                end
            end
            SH_DATA: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == 3'd7) begin
                        s_d.sh = {1'b0, s_q.sh[7:1]};
                        if (s_q.bitn == last_bit) s_d.st = SH_STOP;
                        else                      s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
            end
            SH_STOP: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == 3'd7) s_d.st = SH_IDLE;
                end
            end
            default: s_d.st = SH_IDLE;
        endcase
    end

    always_comb begin
        unique case (s_q.st)
            SH_START: txd = 1'b0;
            SH_DATA:  txd = s_q.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SH_IDLE, sh: '0, bitn: '0, tcnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lu_rx.sv
`timescale 1ns/1ps
module lu_rx import lu_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       len8,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] data
);
    typedef struct packed {
        shift_st_e  st;
        logic [7:0] sh;
        logic [2:0] bitn;
        logic [2:0] tcnt;
    } rx_t;

    localparam logic [2:0] MID = 3'd3;

    rx_t s_d, s_q;
    logic [2:0] last_bit;

    assign last_bit = len8 ? 3'd7 : 3'd6;
    assign data     = len8 ? s_q.sh : {1'b0, s_q.sh[7:1]};

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        unique case (s_q.st)
            SH_IDLE: begin
                if (en && !rxd) begin
                    s_d.st   = SH_START;
                    s_d.tcnt = '0;
                    s_d.bitn = '0;
                end
            end
            SH_START: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == MID && rxd) s_d.st = SH_IDLE;
                    else if (s_q.tcnt == 3'd7)  s_d.st = SH_DATA;
                end
            end
            SH_DATA: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == MID) s_d.sh = {rxd, s_q.sh[7:1]};
                    if (s_q.tcnt == 3'd7) begin
                        if (s_q.bitn == last_bit) s_d.st = SH_STOP;
                        else                      s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
            end
            SH_STOP: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == MID) begin
                        push   = 1'b1;
                        s_d.st = SH_IDLE;
                    end
                end
            end
            default: s_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SH_IDLE, sh: '0, bitn: '0, tcnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lite_uart.sv
`timescale 1ns/1ps
module lite_uart import lu_pkg::*; #(
    parameter int FIFO_DEPTH = 8,
    parameter int BUS_W      = 16,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             txd,
    output logic             rts,
    input  logic             rxd,
    input  logic             cts,
    output logic             irq
);
    typedef struct packed {
        logic [3:0]       ien;
        logic [1:0]       line;
        logic             rts;
        logic [7:0]       scr;
        logic [1:0]       xctl;
        logic [DIV_W-1:0] div;
        logic             ovr;
        logic [1:0]       rx_sync;
        logic [1:0]       cts_sync;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_acc, rd_acc;
    logic tick;
    logic tx_push, tx_pop, tx_clr, tx_full, tx_empty, tx_busy;
    logic rx_push, rx_pop, rx_clr, rx_full, rx_empty, rx_over;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic rx_pend, tx_pend, len8;
    logic [2:0] iid_code;
    logic [3:0] ien_cur;
    logic ovr_cur, tx_en_cur;

    assign wr_acc    = bus_sel && bus_wr;
    assign rd_acc    = bus_sel && !bus_wr;
    assign len8      = r_q.line[0];
    assign ien_cur   = r_q.ien;
    assign ovr_cur   = r_q.ovr;
    assign tx_en_cur = r_q.xctl[1];

    assign tx_push = wr_acc && (bus_addr == A_DATA);
    assign rx_pop  = rd_acc && (bus_addr == A_DATA);
    assign rx_clr  = wr_acc && (bus_addr == A_IID) && bus_wdata[1];
    assign tx_clr  = wr_acc && (bus_addr == A_IID) && bus_wdata[2];
    assign rx_over = rx_push && rx_full && !rx_pop;

    lu_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(r_q.div), .tick(tick)
    );

    lu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .wdata(bus_wdata[7:0]), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    lu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
        .wdata(rx_byte), .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    lu_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(r_q.xctl[1]), .len8(len8),
        .q_empty(tx_empty), .q_data(tx_head), .pop(tx_pop), .txd(txd),
        .busy(tx_busy)
    );

    lu_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(r_q.xctl[0]), .len8(len8),
        .rxd(r_q.rx_sync[1]), .push(rx_push), .data(rx_byte)
    );

    assign rx_pend  = r_q.ien[0] && !rx_empty;
    assign tx_pend  = r_q.ien[1] && !tx_full;
    assign iid_code = rx_pend ? 3'b100 : (tx_pend ? 3'b010 : 3'b001);
    assign irq      = (r_q.ien[3:2] == 2'b11) && (rx_pend || tx_pend);
    assign rts      = r_q.rts;

    always_comb begin
        r_d          = r_q;
        r_d.rx_sync  = {r_q.rx_sync[0], rxd};
        r_d.cts_sync = {r_q.cts_sync[0], cts};
        if (wr_acc) begin
            case (bus_addr)
                A_IEN:   r_d.ien  = bus_wdata[3:0];
                A_LINE:  r_d.line = bus_wdata[1:0];
                A_MODEM: r_d.rts  = bus_wdata[1];
                A_SCR:   r_d.scr  = bus_wdata[7:0];
                A_XCTL:  r_d.xctl = bus_wdata[1:0];
                A_DIV:   r_d.div  = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
        if (rd_acc && bus_addr == A_LSTAT) r_d.ovr = 1'b0;
        if (rx_over)                       r_d.ovr = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            A_IEN:   bus_rdata[3:0] = r_q.ien;
            A_IID:   bus_rdata[2:0] = iid_code;
            A_LINE:  bus_rdata[1:0] = r_q.line;
            A_MODEM: bus_rdata[1]   = r_q.rts;
            A_LSTAT: begin
                bus_rdata[0] = !rx_empty;
                bus_rdata[1] = r_q.ovr;
                bus_rdata[5] = !tx_full;
                bus_rdata[6] = tx_empty && !tx_busy;
            end
            A_MSTAT: bus_rdata[5]   = r_q.cts_sync[1];
            A_SCR:   bus_rdata[7:0] = r_q.scr;
            A_XCTL:  bus_rdata[1:0] = r_q.xctl;
            A_XSTAT: bus_rdata[1:0] = {!tx_full, !rx_empty};
            A_DIV:   bus_rdata[DIV_W-1:0] = r_q.div;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ien: '0, line: '0, rts: 1'b0, scr: '0, xctl: 2'b11,
                     div: '0, ovr: 1'b0, rx_sync: 2'b11, cts_sync: 2'b00};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lite_uart_chk.sv
`timescale 1ns/1ps
module lite_uart_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [3:0]       ien_cur,
    input logic [2:0]       iid_code,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             ovr_cur,
    input logic             tx_en_cur,
    input logic             tx_busy,
    input logic             txd,
    input logic             rts,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata
);
    AST_IRQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_cur[3:2] == 2'b11)); // R6
    AST_IID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iid_code) == 1); // R6
    AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_cur[0] && !rx_empty) |-> (iid_code == 3'b100)); // R6
    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_cur) |-> $past(rx_full)); // R3
    AST_TX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_cur && !tx_busy) |=> !tx_busy); // R8
    AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R2
    AST_RTS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'd4) |=> (rts == $past(bus_wdata[1]))); // R9
endmodule

bind lite_uart lite_uart_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_cur(ien_cur),
    .iid_code(iid_code), .rx_empty(rx_empty), .rx_full(rx_full),
    .ovr_cur(ovr_cur), .tx_en_cur(tx_en_cur), .tx_busy(tx_busy),
    .txd(txd), .rts(rts), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/lite_uart_tb.sv
`timescale 1ns/1ps
module lite_uart_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        txd, rts, rxd, irq;
    logic        cts = 1'b0;
    logic        loop_en = 1'b0, rx_drv = 1'b1;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    assign rxd = loop_en ? txd : rx_drv;

    lite_uart u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .txd(txd), .rts(rts),
        .rxd(rxd), .cts(cts), .irq(irq)
    );

    // fields: [23:16] line control, [15:8] byte sent, [7:0] byte expected
    localparam logic [23:0] VEC [8] = '{
        24'h03_A5_A5, 24'h00_A5_25, 24'h03_00_00, 24'h03_FF_FF,
        24'h00_FF_7F, 24'h03_3C_3C, 24'h00_80_00, 24'h03_81_81
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk); #1 sel = 1'b0;
    endtask

    task automatic poll(input logic [15:0] mask, input int limit, output logic ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int i = 0; i < limit && !ok; i++) begin
            rd(4'd5, v);
            if ((v & mask) != 0) ok = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic ok;
        int lows;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", {15'd0, txd}, 16'h1);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        rd(4'd5, v); chk("R1 line status", v, 16'h0060);
        rd(4'd2, v); chk("R1 identify", v, 16'h0001);

        // R10 unbuilt bits and storage widths
        wr(4'd7, 16'h5AA5); rd(4'd7, v); chk("R10 scratch", v, 16'h00A5);
        wr(4'd1, 16'hFFFF); rd(4'd1, v); chk("R10 enable width", v, 16'h000F);
        wr(4'd3, 16'hFFFF); rd(4'd3, v); chk("R10 line width", v, 16'h0003);
        wr(4'd1, 16'h0000);

        // R2 table walk through loopback
        loop_en = 1'b1;
        wr(4'd10, 16'd2);
        for (int i = 0; i < 8; i++) begin
            wr(4'd3, {8'h00, VEC[i][23:16]});
            wr(4'd0, {8'h00, VEC[i][15:8]});
            poll(16'h0001, 400, ok);
            chk("R2 byte arrived", {15'd0, ok}, 16'h1);
            poll(16'h0040, 400, ok);
            rd(4'd0, v);
            chk("R2 loopback byte", v, {8'h00, VEC[i][7:0]});
        end

        // R2 bit timing with divisor 4
        wr(4'd10, 16'd4); wr(4'd3, 16'd3);
        wr(4'd0, 16'h00A5);
        @(posedge clk);
        repeat (16) @(posedge clk);
        #1 chk("R2 start bit", {15'd0, txd}, 16'h0);
        for (int k = 1; k < 10; k++) begin
            repeat (32) @(posedge clk);
            #1 chk("R2 frame bit", {15'd0, txd}, (k == 9) ? 16'h1 : {15'd0, 8'hA5 >> (k - 1) & 8'h01});
        end
        poll(16'h0040, 400, ok);
        rd(4'd0, v); chk("R2 timed byte", v, 16'h00A5);

        // R11 short low pulse is not a start bit
        loop_en = 1'b0;
        @(negedge clk); rx_drv = 1'b0;
        repeat (8) @(negedge clk);
        rx_drv = 1'b1;
        repeat (400) @(posedge clk);
        rd(4'd5, v); chk("R11 glitch rejected", v, 16'h0060);
        loop_en = 1'b1;
        wr(4'd10, 16'd2);

        // R8 transmitter off holds bytes
        wr(4'd8, 16'h0001);
        wr(4'd0, 16'h0044);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R8 txd quiet", lows[15:0], 16'h0);
        rd(4'd5, v); chk("R8 byte held", v, 16'h0020);
        wr(4'd8, 16'h0003);
        poll(16'h0001, 400, ok);
        poll(16'h0040, 400, ok);
        rd(4'd0, v); chk("R8 released byte", v, 16'h0044);

        // R8 receiver off ignores line
        wr(4'd8, 16'h0002);
        wr(4'd0, 16'h0033);
        poll(16'h0040, 400, ok);
        repeat (50) @(posedge clk);
        rd(4'd5, v); chk("R8 receiver off", v, 16'h0060);
        wr(4'd8, 16'h0003);

        // R7 queue clears
        wr(4'd8, 16'h0001);
        wr(4'd0, 16'h0001); wr(4'd0, 16'h0002); wr(4'd0, 16'h0003);
        rd(4'd5, v); chk("R7 tx queued", v, 16'h0020);
        wr(4'd2, 16'h0004);
        rd(4'd5, v); chk("R7 tx cleared", v, 16'h0060);
        wr(4'd8, 16'h0003);
        repeat (400) @(posedge clk);
        rd(4'd5, v); chk("R7 nothing sent", v, 16'h0060);
        wr(4'd0, 16'h0055);
        poll(16'h0001, 400, ok);
        poll(16'h0040, 400, ok);
        wr(4'd2, 16'h0002);
        rd(4'd5, v); chk("R7 rx cleared", v, 16'h0060);

        // R6 interrupt gating, codes and priority
        wr(4'd1, 16'h0003);
        @(negedge clk); chk("R6 ungated irq", {15'd0, irq}, 16'h0);
        rd(4'd2, v); chk("R6 tx code", v, 16'h0002);
        wr(4'd1, 16'h000E);
        @(negedge clk); chk("R6 tx irq", {15'd0, irq}, 16'h1);
        wr(4'd1, 16'h000D);
        @(negedge clk); chk("R6 no source", {15'd0, irq}, 16'h0);
        rd(4'd2, v); chk("R6 none code", v, 16'h0001);
        wr(4'd0, 16'h0077);
        poll(16'h0001, 400, ok);
        @(negedge clk); chk("R6 rx irq", {15'd0, irq}, 16'h1);
        rd(4'd2, v); chk("R6 rx code", v, 16'h0004);
        wr(4'd1, 16'h000F);
        rd(4'd2, v); chk("R6 rx priority", v, 16'h0004);
        poll(16'h0040, 400, ok);
        rd(4'd0, v); chk("R5 data read", v, 16'h0077);
        rd(4'd2, v); chk("R6 back to tx", v, 16'h0002);
        wr(4'd1, 16'h0000);

        // R3 R4 R5 back-to-back writes, push and pop in one cycle
        for (int i = 0; i < 9; i++) wr(4'd0, 16'h0010 + 16'(i));
        wr(4'd0, 16'h00EE);
        rd(4'd5, v); chk("R4 tx full", v, 16'h0000);
        repeat (2500) @(posedge clk);
        rd(4'd5, v); chk("R3 overrun flagged", v, 16'h0063);
        rd(4'd5, v); chk("R3 overrun cleared", v, 16'h0061);
        for (int i = 0; i < 8; i++) begin
            rd(4'd0, v); chk("R3 order", v, 16'h0010 + 16'(i));
        end
        rd(4'd5, v); chk("R5 rx drained", v, 16'h0060);

        // R9 modem lines
        wr(4'd4, 16'h0002);
        chk("R9 rts set", {15'd0, rts}, 16'h1);
        wr(4'd4, 16'h0000);
        chk("R9 rts clear", {15'd0, rts}, 16'h0);
        @(negedge clk); cts = 1'b1;
        repeat (3) @(posedge clk);
        rd(4'd6, v); chk("R9 cts high", v, 16'h0020);
        @(negedge clk); cts = 1'b0;
        repeat (3) @(posedge clk);
        rd(4'd6, v); chk("R9 cts low", v, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule